// File: doc/BRIEF.md
# Scrambled 2.4 GHz Legacy Packet Framer

This block turns one transmit request into the byte stream that a 2.4 GHz GFSK radio's transmit FIFO expects for a low-cost legacy packet format. A single start pulse latches a transmit address of three to five bytes, a payload of up to 26 bytes and a scramble-enable flag. The block then offers the stream one byte at a time over a valid/ready handshake. The stream is a length byte, a fixed three-byte preamble, the address, the payload and a 16-bit CRC.

The address goes out last-stored byte first. Each payload byte is bit-reversed. With scrambling on, every address and payload byte is XORed with an entry of a scramble sequence indexed by the byte's position. The CRC-16 starts from a nonstandard seed and is folded with a length-dependent XOR-out word before it is appended. The scramble sequence and the XOR-out words live outside the block and are read through two combinational lookup ports.

Top module: `sgf_framer`

## Requirements
- R1: A requested address length below 3 is treated as 3, and one above 5 is treated as 5.
- R2: Address bytes are emitted starting from the highest-indexed stored byte (bits [8*(n-1)+7:8*(n-1)] of `addr`) and ending with byte 0 (bits [7:0]).
- R3: Each payload byte j (bits [8j+7:8j] of `payload`) is emitted bit-reversed, with bit 7 and bit 0 swapped and so on, in increasing j.
- R4: With `scr_en` high, the framed byte at position k (k counts from 0 at the first address byte and continues through the payload) is XORed with `scr_byte` while `scr_idx` equals k. With `scr_en` low, no XOR is applied.
- R5: The CRC uses polynomial 0x1021, processes data MSB first without reflection, starts from 0xB5D2, and covers every address and payload byte exactly as emitted.
- R6: The CRC is XORed with `xo_word` read at `xo_idx` = (address length − 3 + payload length), with `xo_scr` equal to the latched scramble flag so that the scrambled or unscrambled table is selected.
- R7: The two CRC bytes follow the payload, high byte first.
- R8: The stream opens with a length byte equal to address length + payload length + 5, followed by 0x71, 0x0F and 0x55.
- R9: A start pulse is acted on only while the block is idle. A start during a packet leaves that packet unchanged and produces no extra bytes.
- R10: `done` is high for exactly the one cycle after the low CRC byte is accepted, and is low out of reset.
- R11: A start with payload length 0 or above 26 raises `err` for one cycle and emits no bytes.
- R12: While `out_valid` is high and `out_ready` is low, the offered byte and the lookup indices stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| addr_len_req | input | 3 | Requested address length in bytes |
| addr | input | 40 | Address bytes, byte i at bits [8i+7:8i] |
| pay_len | input | 6 | Payload length in bytes |
| payload | input | 208 | Payload bytes, byte j at bits [8j+7:8j] |
| scr_en | input | 1 | Scrambling enable |
| scr_idx | output | 5 | Scramble sequence lookup index |
| scr_byte | input | 8 | Scramble entry at `scr_idx` |
| xo_idx | output | 5 | CRC XOR-out lookup index |
| xo_scr | output | 1 | Selects the scrambled-mode XOR-out table |
| xo_word | input | 16 | XOR-out word at `xo_idx` |
| out_data | output | 8 | Offered stream byte |
| out_valid | output | 1 | Stream byte is valid |
| out_ready | input | 1 | Sink accepts the byte |
| done | output | 1 | One-cycle pulse after the last byte |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The length byte is offered combinationally from the state register, so it is due in the first half-cycle after the clock edge that sampled `start`. Each later byte is due after the edge that accepted its predecessor. `err` is due at the same point as the length byte would be, and `done` one edge after the low CRC byte is accepted. The bench samples every output on the falling edge and pops a behaviourally built queue of expected bytes on each handshake. It compares `done` against a flag that is armed by the handshake on the queue's last byte, so every result is checked at exactly the cycle it is due, under both a continuous and a stalling ready pattern.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

    localparam logic [15:0] SGF_CRC_SEED = 16'hB5D2;
    localparam logic [15:0] SGF_CRC_POLY = 16'h1021;
    localparam logic [7:0]  SGF_PRE_0    = 8'h71;
    localparam logic [7:0]  SGF_PRE_1    = 8'h0F;
    localparam logic [7:0]  SGF_PRE_2    = 8'h55;
    localparam int unsigned SGF_PRE_LEN  = 3;
    localparam int unsigned SGF_CRC_LEN  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEN,
        ST_PRE,
        ST_BODY,
        ST_CRC_HI,
        ST_CRC_LO
    } sgf_state_e;

    function automatic logic [7:0] sgf_bitrev(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = b[7-i];
        end
        return r;
    endfunction

    function automatic logic [15:0] sgf_crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ b[i];
            r  = {r[14:0], 1'b0} ^ (fb ? SGF_CRC_POLY : 16'h0000);
        end
        return r;
    endfunction

endpackage

// File: rtl/sgf_byte_src.sv
module sgf_byte_src
    import sgf_pkg::*;
#(
    parameter int MAX_ADDR = 5,
    parameter int MAX_PAY  = 26,
    parameter int ALW      = 3,
    parameter int POSW     = 5
) (
    input  logic [MAX_ADDR*8-1:0] addr_flat,
    input  logic [MAX_PAY*8-1:0]  pay_flat,
    input  logic [ALW-1:0]        alen,
    input  logic [POSW-1:0]       pos,
    input  logic                  scr_en,
    input  logic [7:0]            scr_byte,
    output logic [7:0]            body_byte
);

    logic [POSW-1:0] alen_w;
    logic [POSW-1:0] a_idx;
    logic [POSW-1:0] p_idx;
    logic [7:0]      a_sel;
    logic [7:0]      p_sel;
    logic [7:0]      raw;

    assign alen_w = POSW'(alen);
    assign a_idx  = alen_w - pos - POSW'(1);
    assign p_idx  = pos - alen_w;

    // Address walks downward from the last stored byte.
    always_comb begin
        a_sel = '0;
        for (int i = 0; i < MAX_ADDR; i++) begin
            if (a_idx == POSW'(i)) a_sel = addr_flat[i*8 +: 8];
        end
    end

    // Payload walks upward, each byte mirrored.
    always_comb begin
        p_sel = '0;
        for (int j = 0; j < MAX_PAY; j++) begin
            if (p_idx == POSW'(j)) p_sel = sgf_bitrev(pay_flat[j*8 +: 8]);
        end
    end

    assign raw       = (pos < alen_w) ? a_sel : p_sel;
    assign body_byte = raw ^ (scr_en ? scr_byte : 8'h00);

endmodule

// File: rtl/sgf_crc_acc.sv
module sgf_crc_acc
    import sgf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc <= SGF_CRC_SEED;
        end else if (en) begin
            crc <= sgf_crc_step(crc, din);
        end
    end

endmodule

// File: rtl/sgf_framer.sv
module sgf_framer
    import sgf_pkg::*;
#(
    parameter int MAX_ADDR = 5,
    parameter int MIN_ADDR = 3,
    parameter int MAX_PAY  = 26,
    localparam int ALW     = $clog2(MAX_ADDR + 1),
    localparam int PLW     = $clog2(MAX_PAY + 1) + 1,
    localparam int POSW    = $clog2(MAX_ADDR + MAX_PAY + 1),
    localparam int XW      = $clog2(MAX_ADDR - MIN_ADDR + MAX_PAY + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [ALW-1:0]        addr_len_req,
    input  logic [MAX_ADDR*8-1:0] addr,
    input  logic [PLW-1:0]        pay_len,
    input  logic [MAX_PAY*8-1:0]  payload,
    input  logic                  scr_en,
    output logic [POSW-1:0]       scr_idx,
    input  logic [7:0]            scr_byte,
    output logic [XW-1:0]         xo_idx,
    output logic                  xo_scr,
    input  logic [15:0]           xo_word,
    output logic [7:0]            out_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic                  done,
    output logic                  err
);

    sgf_state_e            state;
    logic [POSW-1:0]       cnt;
    logic [ALW-1:0]        alen_q;
    logic [PLW-1:0]        plen_q;
    logic                  scr_q;
    logic [MAX_ADDR*8-1:0] addr_q;
    logic [MAX_PAY*8-1:0]  pay_q;
    logic                  done_q;
    logic                  err_q;

    logic [ALW-1:0]        alen_c;
    logic                  len_bad;
    logic                  go;
    logic                  acc;
    logic [POSW-1:0]       total;
    logic [7:0]            body_byte;
    logic [15:0]           crc_run;
    logic [15:0]           crc_fin;

    // Request decode
    always_comb begin
        if (addr_len_req < ALW'(MIN_ADDR))      alen_c = ALW'(MIN_ADDR);
        else if (addr_len_req > ALW'(MAX_ADDR)) alen_c = ALW'(MAX_ADDR);
        else                                    alen_c = addr_len_req;
    end

    assign len_bad = (pay_len == '0) || (pay_len > PLW'(MAX_PAY));
    assign go      = (state == ST_IDLE) && start && !len_bad;
    assign acc     = out_valid && out_ready;
    assign total   = POSW'(alen_q) + POSW'(plen_q);

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            alen_q <= ALW'(MIN_ADDR);
            plen_q <= PLW'(1);
            scr_q  <= 1'b0;
            addr_q <= '0;
            pay_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start && len_bad) begin
                        err_q <= 1'b1;
                    end else if (go) begin
                        alen_q <= alen_c;
                        plen_q <= pay_len;
                        scr_q  <= scr_en;
                        addr_q <= addr;
                        pay_q  <= payload;
                        cnt    <= '0;
                        state  <= ST_LEN;
                    end
                end
                ST_LEN: begin
                    if (acc) begin
                        cnt   <= '0;
                        state <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (acc) begin
                        if (cnt == POSW'(SGF_PRE_LEN - 1)) begin
                            cnt   <= '0;
                            state <= ST_BODY;
                        end else begin
                            cnt <= cnt + POSW'(1);
                        end
                    end
                end
                ST_BODY: begin
                    if (acc) begin
                        if (cnt == total - POSW'(1)) begin
                            cnt   <= '0;
                            state <= ST_CRC_HI;
                        end else begin
                            cnt <= cnt + POSW'(1);
                        end
                    end
                end
                ST_CRC_HI: begin
                    if (acc) state <= ST_CRC_LO;
                end
                ST_CRC_LO: begin
                    if (acc) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    sgf_byte_src #(
        .MAX_ADDR (MAX_ADDR),
        .MAX_PAY  (MAX_PAY),
        .ALW      (ALW),
        .POSW     (POSW)
    ) u_src (
        .addr_flat (addr_q),
        .pay_flat  (pay_q),
        .alen      (alen_q),
        .pos       (cnt),
        .scr_en    (scr_q),
        .scr_byte  (scr_byte),
        .body_byte (body_byte)
    );

    sgf_crc_acc u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (go),
        .en    (acc && (state == ST_BODY)),
        .din   (body_byte),
        .crc   (crc_run)
    );

    assign scr_idx = cnt;
    assign xo_idx  = XW'(alen_q) - XW'(MIN_ADDR) + XW'(plen_q);
    assign xo_scr  = scr_q;
    assign crc_fin = crc_run ^ xo_word;

    always_comb begin
        unique case (state)
            ST_LEN:    out_data = 8'(total) + 8'(SGF_PRE_LEN + SGF_CRC_LEN);
            ST_PRE: begin
                if (cnt == POSW'(0))      out_data = SGF_PRE_0;
                else if (cnt == POSW'(1)) out_data = SGF_PRE_1;
                else                      out_data = SGF_PRE_2;
            end
            ST_BODY:   out_data = body_byte;
            ST_CRC_HI: out_data = crc_fin[15:8];
            ST_CRC_LO: out_data = crc_fin[7:0];
            default:   out_data = 8'h00;
        endcase
    end

    assign out_valid = (state != ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;

    AST_ALEN_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (alen_q >= ALW'(MIN_ADDR)) && (alen_q <= ALW'(MAX_ADDR))); // R1
    AST_SCR_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BODY) |-> (scr_idx < total)); // R4
    AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (out_valid && start) |=> $stable(alen_q) && $stable(plen_q) && $stable(scr_q)); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        err |-> !out_valid); // R11
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(scr_idx) && $stable(xo_idx) && $stable(state)); // R12

endmodule

// File: tb/sgf_framer_tb.sv
module sgf_framer_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [2:0]   addr_len_req = 3'd3;
    logic [39:0]  addr = '0;
    logic [5:0]   pay_len = 6'd1;
    logic [207:0] payload = '0;
    logic         scr_en = 1'b0;
    logic [4:0]   scr_idx;
    logic [7:0]   scr_byte;
    logic [4:0]   xo_idx;
    logic         xo_scr;
    logic [15:0]  xo_word;
    logic [7:0]   out_data;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic         done;
    logic         err;

    int total_n = 0;
    int bad_n   = 0;
    bit rnd_rdy = 1'b0;
    bit pend_done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    sgf_framer u_dut (
        .clk(clk), .rst(rst), .start(start), .addr_len_req(addr_len_req),
        .addr(addr), .pay_len(pay_len), .payload(payload), .scr_en(scr_en),
        .scr_idx(scr_idx), .scr_byte(scr_byte), .xo_idx(xo_idx), .xo_scr(xo_scr),
        .xo_word(xo_word), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .done(done), .err(err)
    );

    // Lookup tables seen by the block (behavioural ROMs)
    function automatic logic [7:0] scr_tab(input int k);
        return 8'((k * 37 + 90) ^ (k << 3));
    endfunction
    function automatic logic [15:0] xo_tab(input int idx, input bit s);
        return 16'(idx * 16'h0911) ^ (s ? 16'hA5A5 : 16'h3C3C);
    endfunction
    assign scr_byte = scr_tab(int'(scr_idx));
    assign xo_word  = xo_tab(int'(xo_idx), xo_scr);

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        repeat (8) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total_n++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: build the expected stream
    task automatic build_expected(input int alr, input int pl, input bit s,
                                  input logic [39:0] a, input logic [207:0] p);
        int al;
        logic [15:0] c;
        logic [7:0] b;
        al = (alr < 3) ? 3 : ((alr > 5) ? 5 : alr);       // R1
        exp_q.push_back(8'(al + pl + 5)); tag_q.push_back("R8 length");
        exp_q.push_back(8'h71); tag_q.push_back("R8 preamble0");
        exp_q.push_back(8'h0F); tag_q.push_back("R8 preamble1");
        exp_q.push_back(8'h55); tag_q.push_back("R8 preamble2");
        c = 16'hB5D2;
        for (int i = 0; i < al; i++) begin
            b = a[(al - 1 - i) * 8 +: 8];
            if (s) b = b ^ scr_tab(i);                      // R4
            c = ref_crc(c, b);
            exp_q.push_back(b); tag_q.push_back(s ? "R2/R4 address" : "R2 address");
        end
        for (int j = 0; j < pl; j++) begin
            b = {<<{p[j*8 +: 8]}};
            if (s) b = b ^ scr_tab(al + j);
            c = ref_crc(c, b);
            exp_q.push_back(b); tag_q.push_back(s ? "R3/R4 payload" : "R3 payload");
        end
        c = c ^ xo_tab(al - 3 + pl, s);                     // R6
        exp_q.push_back(c[15:8]); tag_q.push_back("R5/R6/R7 crc high");
        exp_q.push_back(c[7:0]);  tag_q.push_back("R5/R6/R7 crc low");
    endtask

    // Sink ready pattern
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = rnd_rdy ? (lfsr[0] | lfsr[5]) : 1'b1;
        end
    end

    // Per-cycle comparison against the reference queue
    always @(negedge clk) begin
        if (rst) begin
            pend_done = 1'b0;
        end else begin
            if (pend_done || done) chk(done === pend_done, "R10 done pulse", done, pend_done);
            pend_done = 1'b0;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected byte", out_data, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(out_data === e, t, out_data, e);
                    if (exp_q.size() == 0) pend_done = 1'b1;
                end
            end
        end
    end

    task automatic fill(input int seed);
        for (int i = 0; i < 5; i++)  addr[i*8 +: 8] = 8'(seed * 13 + i * 71 + 5);
        for (int j = 0; j < 26; j++) payload[j*8 +: 8] = 8'(seed * 7 + j * 29 + 1);
    endtask

    task automatic send(input int alr, input int pl, input bit s, input int seed, input bit poke);
        fill(seed);
        @(posedge clk); #1;
        addr_len_req = 3'(alr); pay_len = 6'(pl); scr_en = s; start = 1'b1;
        build_expected(alr, pl, s, addr, payload);
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            // R9: start while busy must be ignored
            repeat (6) @(posedge clk);
            #1;
            fill(seed + 99);
            addr_len_req = 3'd4; pay_len = 6'd3; scr_en = ~s; start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 idle after packet", out_valid, 0);
    endtask

    task automatic send_bad(input int pl);
        @(posedge clk); #1;
        pay_len = 6'(pl); addr_len_req = 3'd4; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk(err === 1'b1, "R11 err raised", err, 1);
        chk(out_valid === 1'b0, "R11 no bytes", out_valid, 0);
        @(negedge clk);
        chk(err === 1'b0, "R11 err one cycle", err, 0);
        repeat (3) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R11 stays idle", out_valid, 0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total_n, bad_n);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 reset valid", out_valid, 0);
        chk(done === 1'b0, "R10 reset done", done, 0);
        chk(err === 1'b0, "R11 reset err", err, 0);

        send(3, 1, 1'b1, 1, 1'b0);        // smallest packet, scrambled
        send(5, 26, 1'b1, 2, 1'b0);       // largest packet
        send(4, 7, 1'b0, 3, 1'b0);        // R4 off, R6 unscrambled table
        send(1, 2, 1'b1, 4, 1'b0);        // R1 clamp up
        send(7, 3, 1'b0, 5, 1'b0);        // R1 clamp down
        send_bad(0);                      // R11
        send_bad(27);                     // R11
        rnd_rdy = 1'b1;                   // R12 stalls
        send(5, 26, 1'b1, 6, 1'b0);
        send(4, 12, 1'b0, 7, 1'b1);       // R9 busy start
        send(3, 20, 1'b1, 8, 1'b1);
        for (int n = 0; n < 12; n++) begin
            send(n % 8, 1 + (n * 5) % 26, n[0], 20 + n, 1'b0);
        end
        rnd_rdy = 1'b0;
        send(5, 9, 1'b0, 40, 1'b1);
        send_bad(31);

        $display("test done: total=%0d bad=%0d", total_n, bad_n);
        $finish;
    end

endmodule